// File: doc/BRIEF.md
# Interleaved Cache Line Fill Controller

This controller fills one cache line of four 32-bit words from a main memory built as four low-order interleaved banks. Address bits [3:2] of a word pick its bank, so the four words of one aligned 16-byte line sit at the same local address in all four banks. From a single line request the controller sends one shared bank address, reads all four banks in the same cycle, and waits out the common access latency. It then returns the words one per clock over a 32-bit narrow bus. With the default latency a line costs 1 address clock, 15 access clocks and 4 transfer clocks, which is 20 clocks in total.

The cache starts a fill with `req_valid` and a byte address while `req_ready` is high. The words then appear on `word_valid`/`word_data` in ascending bank order, and `line_done` marks the last one. A separate combinational decoder turns the low address bits and an access size into active-low little-endian byte enables for single-word writes. It flags misaligned or reserved accesses.

Top module: `line_fill_ctrl`

## Requirements
- R1: The words of a line come out in bank order. The k-th word (k = 0..3) is the value read from bank k, which is the bank whose address bits [3:2] equal k.
- R2: On a fill, `bank_rd_en` is 4'b1111 for exactly one cycle: the cycle that follows the accepting clock edge. `bank_addr` carries request address bits [31:4] in that cycle and stays stable until the fill ends.
- R3: If the request is accepted at edge 0, bank data is sampled at edge LATENCY+1. Word k is valid in the cycle that follows edge LATENCY+1+k, and `word_valid` is low at every other point of the fill.
- R4: `line_done` is high together with the fourth word and at no other time.
- R5: `req_ready` is high only when the controller is idle. While a fill runs, a request held on the inputs causes no new bank read. The ready signal returns high in the cycle after edge LATENCY+5.
- R6: Request address bits [3:0] are ignored. Every fill starts at the line-aligned address.
- R7: `wr_be_n` bit i is low when byte lane i (data bits 8i+7..8i, little-endian) is written. A byte (`wr_size` 00) at offset o clears bit o only. A halfword (01) at offset 0 gives 1100, and at offset 2 it gives 0011. A word (10) at offset 0 gives 0000.
- R8: A halfword at an odd offset, a word at a nonzero offset, and the reserved size 11 all raise `wr_misalign` and give `wr_be_n` = 1111.
- R9: After reset, `req_ready` is 1, and `word_valid`, `line_done` and `bank_rd_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Line fill request |
| req_addr | input | 32 | Byte address inside the wanted line |
| req_ready | output | 1 | Controller idle, request will be taken |
| bank_rd_en | output | 4 | Read strobe, one bit per bank |
| bank_addr | output | 28 | Bank-local address shared by all banks |
| bank_rdata | input | 128 | Read data, bank b on bits 32b+31..32b |
| word_valid | output | 1 | Returned word present |
| word_data | output | 32 | Returned word |
| line_done | output | 1 | Last word of the line |
| wr_offs | input | 2 | Byte offset of a single-word write |
| wr_size | input | 2 | Write size: 00 byte, 01 halfword, 10 word, 11 reserved |
| wr_be_n | output | 4 | Active-low byte enables |
| wr_misalign | output | 1 | Misaligned or reserved write |

## Verification
The assertions assume the cache drops or keeps a request as it likes. They do not assume the banks deliver data on time, because the bank model in the stimulus outputs a garbage value until LATENCY-1 clocks after its read strobe. An early sample would therefore show up as wrong data rather than as a property violation. Random line addresses come from a fixed seed and also cover the low four bits. Some fills hold a second request on the inputs for the whole busy window, so that an ignored request is exercised. The byte-enable decoder is swept over every offset and size, so no input lies outside the encodings the requirements define.

// File: rtl/lfc_pkg.sv
package lfc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_WAIT = 2'd2,
        ST_XFER = 2'd3
    } fill_state_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

endpackage

// File: rtl/lfc_sequencer.sv
module lfc_sequencer
    import lfc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int NUM_BANKS  = 4,
    parameter int WORD_BYTES = 4,
    parameter int LATENCY    = 15,
    localparam int SEL_W     = $clog2(NUM_BANKS),
    localparam int OFFS_W    = SEL_W + $clog2(WORD_BYTES),
    localparam int LINE_AW   = ADDR_W - OFFS_W,
    localparam int CNT_W     = $clog2(LATENCY + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_addr,
    output logic               req_ready,
    output logic               issue,
    output logic               capture,
    output logic               xfer_valid,
    output logic               xfer_last,
    output logic [SEL_W-1:0]   xfer_idx,
    output logic [LINE_AW-1:0] line_addr
);

    typedef struct packed {
        fill_state_e        state;
        logic [CNT_W-1:0]   cnt;
        logic [SEL_W-1:0]   idx;
        logic [LINE_AW-1:0] line;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    seq_d.state = ST_ADDR;
                    seq_d.line  = req_addr[ADDR_W-1:OFFS_W];
                end
            end
            ST_ADDR: begin
                seq_d.state = ST_WAIT;
                seq_d.cnt   = CNT_W'(LATENCY - 1);
            end
            ST_WAIT: begin
                if (seq_q.cnt == '0) begin
                    seq_d.state = ST_XFER;
                    seq_d.idx   = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            ST_XFER: begin
                if (seq_q.idx == SEL_W'(NUM_BANKS - 1)) begin
                    seq_d.state = ST_IDLE;
                    seq_d.idx   = '0;
                end else begin
                    seq_d.idx = seq_q.idx + 1'b1;
                end
            end
            default: seq_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{state: ST_IDLE, cnt: '0, idx: '0, line: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign req_ready  = (seq_q.state == ST_IDLE);
    assign issue      = (seq_q.state == ST_ADDR);
    assign capture    = (seq_q.state == ST_WAIT) && (seq_q.cnt == '0);
    assign xfer_valid = (seq_q.state == ST_XFER);
    assign xfer_last  = xfer_valid && (seq_q.idx == SEL_W'(NUM_BANKS - 1));
    assign xfer_idx   = seq_q.idx;
    assign line_addr  = seq_q.line;

endmodule

// File: rtl/lfc_bank_lane.sv
module lfc_bank_lane #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [WORD_W-1:0] rdata,
    output logic [WORD_W-1:0] held
);

    logic [WORD_W-1:0] word_d, word_q;

    always_comb begin
        word_d = word_q;
        if (capture) begin
            word_d = rdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else begin
            word_q <= word_d;
        end
    end

    assign held = word_q;

endmodule

// File: rtl/lfc_byte_en.sv
module lfc_byte_en
    import lfc_pkg::*;
#(
    parameter int WORD_BYTES = 4,
    localparam int BYTE_W    = $clog2(WORD_BYTES)
) (
    input  logic [BYTE_W-1:0]     offs,
    input  logic [1:0]            size,
    output logic [WORD_BYTES-1:0] be_n,
    output logic                  misalign
);

    int                    span;
    logic [WORD_BYTES-1:0] lane_mask;

    always_comb begin
        span      = 1 << int'(size);
        misalign  = (size == SZ_RSVD) || (span > WORD_BYTES)
                    || ((int'(offs) % span) != 0);
        lane_mask = '0;
        for (int i = 0; i < WORD_BYTES; i++) begin
            if (i >= int'(offs) && i < int'(offs) + span) begin
                lane_mask[i] = 1'b1;
            end
        end
        be_n = misalign ? '1 : ~lane_mask;
    end

endmodule

// File: rtl/line_fill_ctrl.sv
module line_fill_ctrl #(
    parameter int ADDR_W     = 32,
    parameter int WORD_W     = 32,
    parameter int NUM_BANKS  = 4,
    parameter int LATENCY    = 15,
    localparam int WORD_BYTES = WORD_W / 8,
    localparam int BYTE_W    = $clog2(WORD_BYTES),
    localparam int SEL_W     = $clog2(NUM_BANKS),
    localparam int OFFS_W    = SEL_W + BYTE_W,
    localparam int LINE_AW   = ADDR_W - OFFS_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic [ADDR_W-1:0]           req_addr,
    output logic                        req_ready,
    output logic [NUM_BANKS-1:0]        bank_rd_en,
    output logic [LINE_AW-1:0]          bank_addr,
    input  logic [NUM_BANKS*WORD_W-1:0] bank_rdata,
    output logic                        word_valid,
    output logic [WORD_W-1:0]           word_data,
    output logic                        line_done,
    input  logic [BYTE_W-1:0]           wr_offs,
    input  logic [1:0]                  wr_size,
    output logic [WORD_BYTES-1:0]       wr_be_n,
    output logic                        wr_misalign
);

    logic              issue;
    logic              capture;
    logic              xfer_valid;
    logic              xfer_last;
    logic [SEL_W-1:0]  xfer_idx;
    logic [WORD_W-1:0] lane_word [NUM_BANKS];

    lfc_sequencer #(
        .ADDR_W     (ADDR_W),
        .NUM_BANKS  (NUM_BANKS),
        .WORD_BYTES (WORD_BYTES),
        .LATENCY    (LATENCY)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .req_ready  (req_ready),
        .issue      (issue),
        .capture    (capture),
        .xfer_valid (xfer_valid),
        .xfer_last  (xfer_last),
        .xfer_idx   (xfer_idx),
        .line_addr  (bank_addr)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_lane
        lfc_bank_lane #(
            .WORD_W (WORD_W)
        ) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .capture (capture),
            .rdata   (bank_rdata[b*WORD_W +: WORD_W]),
            .held    (lane_word[b])
        );
        assign bank_rd_en[b] = issue;
    end

    assign word_valid = xfer_valid;
    assign word_data  = xfer_valid ? lane_word[xfer_idx] : '0;
    assign line_done  = xfer_last;

    lfc_byte_en #(
        .WORD_BYTES (WORD_BYTES)
    ) u_be (
        .offs     (wr_offs),
        .size     (wr_size),
        .be_n     (wr_be_n),
        .misalign (wr_misalign)
    );

endmodule

// File: rtl/lfc_checker.sv
module lfc_checker #(
    parameter int ADDR_W     = 32,
    parameter int WORD_W     = 32,
    parameter int NUM_BANKS  = 4,
    parameter int LATENCY    = 15,
    localparam int WORD_BYTES = WORD_W / 8,
    localparam int BYTE_W    = $clog2(WORD_BYTES),
    localparam int SEL_W     = $clog2(NUM_BANKS),
    localparam int OFFS_W    = SEL_W + BYTE_W,
    localparam int LINE_AW   = ADDR_W - OFFS_W,
    localparam int GAP_MAX   = LATENCY + NUM_BANKS + 2,
    localparam int GAP_W     = $clog2(GAP_MAX + 1)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  req_valid,
    input logic [ADDR_W-1:0]     req_addr,
    input logic                  req_ready,
    input logic [NUM_BANKS-1:0]  bank_rd_en,
    input logic [LINE_AW-1:0]    bank_addr,
    input logic                  word_valid,
    input logic                  line_done,
    input logic [BYTE_W-1:0]     wr_offs,
    input logic [1:0]            wr_size,
    input logic [WORD_BYTES-1:0] wr_be_n,
    input logic                  wr_misalign
);

    logic [GAP_W-1:0] gap_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= '0;
        end else if (|bank_rd_en) begin
            gap_q <= '0;
        end else if (gap_q != GAP_W'(GAP_MAX)) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    assert_all_banks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|bank_rd_en) |-> (bank_rd_en == '1));

    assert_single_issue_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|bank_rd_en) |=> (bank_rd_en == '0));

    assert_line_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (bank_addr == $past(req_addr[ADDR_W-1:OFFS_W])));

    assert_word_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> (gap_q >= GAP_W'(LATENCY) && gap_q <= GAP_W'(LATENCY + NUM_BANKS - 1)));

    assert_stream_gapless_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && !line_done) |=> word_valid);

    assert_done_with_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |-> word_valid);

    assert_done_then_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |=> req_ready);

    assert_busy_not_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((|bank_rd_en) || word_valid) |-> !req_ready);

    assert_byte_one_lane_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_size == 2'b00) |-> ($countones(~wr_be_n) == 1));

    assert_misalign_blank_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_misalign |-> (wr_be_n == '1));

    assert_rsvd_size_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_size == 2'b11) |-> wr_misalign);

    assert_reset_idle_R9: assert property (@(posedge clk)
        !rst_n |=> (req_ready && !word_valid && (bank_rd_en == '0)));

endmodule

bind line_fill_ctrl lfc_checker #(
    .ADDR_W    (ADDR_W),
    .WORD_W    (WORD_W),
    .NUM_BANKS (NUM_BANKS),
    .LATENCY   (LATENCY)
) u_chk (.*);

// File: tb/line_fill_ctrl_test.sv
`timescale 1ns/1ps
module line_fill_ctrl_test;

    localparam int LAT = 15;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [31:0]  req_addr = '0;
    logic         req_ready;
    logic [3:0]   bank_rd_en;
    logic [27:0]  bank_addr;
    logic [127:0] bank_rdata;
    logic         word_valid;
    logic [31:0]  word_data;
    logic         line_done;
    logic [1:0]   wr_offs = '0;
    logic [1:0]   wr_size = '0;
    logic [3:0]   wr_be_n;
    logic         wr_misalign;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    line_fill_ctrl #(.LATENCY(LAT)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .bank_rd_en(bank_rd_en), .bank_addr(bank_addr),
        .bank_rdata(bank_rdata), .word_valid(word_valid), .word_data(word_data),
        .line_done(line_done), .wr_offs(wr_offs), .wr_size(wr_size),
        .wr_be_n(wr_be_n), .wr_misalign(wr_misalign)
    );

    function automatic logic [31:0] mem_word(input int b, input logic [27:0] la);
        return (32'(la) * 32'h9E3779B1) ^ (32'(b) * 32'h01010101) ^ 32'h00C3_5A00;
    endfunction

    function automatic logic [4:0] exp_be(input logic [1:0] o, input logic [1:0] s);
        // returns {misalign, be_n}
        case (s)
            2'b00: return {1'b0, ~(4'b0001 << o)};
            2'b01: begin
                if (o == 2'd0) return {1'b0, 4'b1100};
                if (o == 2'd2) return {1'b0, 4'b0011};
                return 5'b11111;
            end
            2'b10: return (o == 2'd0) ? 5'b00000 : 5'b11111;
            default: return 5'b11111;
        endcase
    endfunction

    // bank model: data is garbage until LAT-1 clocks after the read strobe
    logic [27:0] bm_addr [4];
    int          bm_age  [4];

    always @(posedge clk) begin
        for (int b = 0; b < 4; b++) begin
            if (!rst_n) begin
                bm_age[b]  <= 1000;
                bm_addr[b] <= '0;
            end else if (bank_rd_en[b]) begin
                bm_addr[b] <= bank_addr;
                bm_age[b]  <= 0;
            end else if (bm_age[b] < 1000) begin
                bm_age[b] <= bm_age[b] + 1;
            end
        end
    end

    always_comb begin
        for (int b = 0; b < 4; b++) begin
            bank_rdata[b*32 +: 32] = (bm_age[b] >= LAT - 1) ? mem_word(b, bm_addr[b])
                                                           : (32'hDEAD0000 | 32'(b));
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_fill(input logic [31:0] a, input bit hold, input logic [31:0] other);
        logic [27:0] la;
        bit early_ok, ready_ok, addr_ok;
        int issues;
        la = a[31:4];
        early_ok = 1; ready_ok = 1; addr_ok = 1; issues = 0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R5 idle ready", 64'(req_ready), 64'd1);
        req_valid = 1'b1;
        req_addr  = a;
        for (int n = 1; n <= LAT + 6; n++) begin
            @(negedge clk);
            if (n == 1) begin
                req_valid = hold;
                req_addr  = other;
                chk(bank_rd_en == 4'hF, "R2 issue all banks", 64'(bank_rd_en), 64'hF);
                chk(bank_addr == la, "R6 line address", 64'(bank_addr), 64'(la));
            end
            if (|bank_rd_en) issues++;
            if (n < LAT + 6 && req_ready) ready_ok = 0;
            if (bank_addr != la) addr_ok = 0;
            if (n <= LAT + 1 && (word_valid || line_done)) early_ok = 0;
            if (n >= LAT + 2 && n <= LAT + 5) begin
                int k;
                k = n - (LAT + 2);
                chk(word_valid == 1'b1, "R3 word valid", 64'(word_valid), 64'd1);
                chk(word_data == mem_word(k, la), "R1 word order", 64'(word_data),
                    64'(mem_word(k, la)));
                chk(line_done == (k == 3), "R4 done with last", 64'(line_done), 64'(k == 3));
            end
            if (n == LAT + 6) begin
                req_valid = 1'b0;
                chk(req_ready == 1'b1, "R5 ready returns", 64'(req_ready), 64'd1);
                chk(!word_valid && !line_done, "R3 stream ends", 64'(word_valid), 64'd0);
            end
        end
        chk(early_ok, "R3 nothing before latency", 64'(early_ok), 64'd1);
        chk(ready_ok, "R5 ready low while busy", 64'(ready_ok), 64'd1);
        chk(issues == 1, "R5 busy request ignored", 64'(issues), 64'd1);
        chk(addr_ok, "R2 bank address stable", 64'(addr_ok), 64'd1);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk(req_ready == 1'b1, "R9 reset ready", 64'(req_ready), 64'd1);
        chk(!word_valid && !line_done && bank_rd_en == 4'h0, "R9 reset outputs",
            64'({word_valid, line_done, bank_rd_en}), 64'd0);

        // directed corners
        do_fill(32'h0000_0000, 1'b0, 32'h0);
        do_fill(32'hFFFF_FFFF, 1'b1, 32'h1111_1110);
        do_fill(32'h1234_567F, 1'b0, 32'h0);
        do_fill(32'h1234_5670, 1'b1, 32'hFFFF_FFF0);
        do_fill(32'h8000_0009, 1'b0, 32'h0);

        // random fills
        for (int i = 0; i < 12; i++) begin
            do_fill($urandom, 1'($urandom), $urandom);
        end

        // byte enables, every offset and size
        for (int s = 0; s < 4; s++) begin
            for (int o = 0; o < 4; o++) begin
                logic [4:0] e;
                @(negedge clk);
                wr_offs = 2'(o);
                wr_size = 2'(s);
                #1;
                e = exp_be(2'(o), 2'(s));
                if (e[4])
                    chk({wr_misalign, wr_be_n} == e, "R8 misalign", 64'({wr_misalign, wr_be_n}),
                        64'(e));
                else
                    chk({wr_misalign, wr_be_n} == e, "R7 byte enables",
                        64'({wr_misalign, wr_be_n}), 64'(e));
            end
        end

        // random byte-enable mix
        for (int i = 0; i < 20; i++) begin
            logic [4:0] e;
            @(negedge clk);
            wr_offs = 2'($urandom);
            wr_size = 2'($urandom);
            #1;
            e = exp_be(wr_offs, wr_size);
            chk({wr_misalign, wr_be_n} == e, "R7 R8 random enables",
                64'({wr_misalign, wr_be_n}), 64'(e));
        end

        repeat (2) @(negedge clk);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule